// File: doc/BRIEF.md
# Physical Memory Access Guard

This block decides whether a physical access may go ahead. It holds a fixed set of ordered guard entries. Each entry stores an upper address bound and an 8-bit setting made of read, write and execute grants, a match-mode field and a lock flag. An entry covers one contiguous range. The range starts at the bound of the entry below it and ends just before the entry's own bound. Entry 0 starts at address zero.

The check port is purely combinational. It takes a physical address, which is already translated if paging is in use, together with the access kind and the privilege of the requester. It returns a single allow flag in the same cycle. The entries are loaded through a one-cycle write port. A write takes effect only when it comes from the most privileged level.

Top module: `mem_guard`

## Requirements
- R1: After reset every entry has bound 0 and setting 0, so every entry is off. Every access kind at every privilege is then allowed.
- R2: A write changes state only when `cfgWe` is 1, `cfgPriv` is 2'b11 (machine) and `cfgIdx` is below NUM_REGIONS. All other writes are ignored.
- R3: When `cfgSel` is 0, a write stores the full `cfgWdata` as the entry's bound. When `cfgSel` is 1, a write stores `cfgWdata[7:0]` as the setting: bit 0 grants read, bit 1 grants write, bit 2 grants execute, bits 4:3 hold the mode and bit 7 is the lock.
- R4: Entry i matches address A when its mode is 2'b01 and bound(i-1) <= A < bound(i). For entry 0 the lower bound is zero.
- R5: `chkType` selects the access kind: 0 is read, 1 is write, 2 is execute. A deciding entry allows the access only if the grant bit for that kind is set. Type 3 is never granted.
- R6: When several entries match, the lowest-numbered one alone decides the result.
- R7: A non-machine access (privilege 2'b00, 2'b01 or 2'b10) that matches no entry is denied if any entry has mode 2'b01. It is allowed if no entry has that mode.
- R8: A machine access (2'b11) is allowed unless its deciding entry is locked. A locked deciding entry applies its grants to machine accesses too.
- R9: Once an entry is locked, writes to its bound and to its setting are ignored until reset.
- R10: An entry whose mode is 2'b00 or a reserved value (2'b10 or 2'b11) never matches. An entry whose bound is not above the bound of the entry below it never matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write strobe for an entry |
| cfgPriv | input | 2 | Privilege of the writer |
| cfgSel | input | 1 | 0 writes the bound, 1 writes the setting |
| cfgIdx | input | IDX_W | Entry number being written |
| cfgWdata | input | ADDR_W | Write data |
| chkAddr | input | ADDR_W | Physical address under check |
| chkType | input | 2 | Access kind |
| chkPriv | input | 2 | Privilege of the access |
| chkAllow | output | 1 | 1 when the access may proceed |

## Verification
The bench builds the block with NUM_REGIONS = 6 and ADDR_W = 16. Six entries give a 3-bit index, so indices 6 and 7 exist on the port and can show that out-of-range writes are dropped. Sixteen-bit addresses keep bounds readable while still exercising full-width storage. With six entries, bounds can be arranged out of order, which produces empty ranges and an upper entry that overlaps lower ones. This makes the lowest-index rule observable.

// File: rtl/mem_guard_pkg.sv
package mem_guard_pkg;

  localparam int MAX_IDX_W = 4;

  localparam logic [1:0] PRIV_MACH  = 2'b11;
  localparam logic [1:0] MODE_RANGE = 2'b01;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  typedef struct packed {
    logic       lock;
    logic [1:0] spare;
    logic [1:0] mode;
    logic       x;
    logic       w;
    logic       r;
  } entry_cfg_t;

  typedef struct packed {
    logic                 addrWr;
    logic                 cfgWr;
    logic [MAX_IDX_W-1:0] idx;
  } wr_strobe_t;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
    logic lock;
  } perm_t;

endpackage

// File: rtl/mem_guard_match.sv
module mem_guard_match #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] lowBound,
  input  logic [ADDR_W-1:0] highBound,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        mode,
  output logic              hit
);
  import mem_guard_pkg::*;

  logic aboveLow;
  logic belowHigh;

  assign aboveLow  = (addr >= lowBound);
  assign belowHigh = (addr < highBound);
  assign hit       = (mode == MODE_RANGE) && aboveLow && belowHigh;

endmodule

// File: rtl/mem_guard_dp.sv
module mem_guard_dp #(
  parameter int NUM_REGIONS = 16,
  parameter int ADDR_W      = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  mem_guard_pkg::wr_strobe_t     strobe,
  input  logic [ADDR_W-1:0]             wdata,
  input  logic [ADDR_W-1:0]             chkAddr,
  output logic [NUM_REGIONS-1:0]        lockVec,
  output logic [NUM_REGIONS-1:0]        enVec,
  output logic [NUM_REGIONS-1:0]        matchVec,
  output logic [NUM_REGIONS-1:0]        selVec,
  output logic                          selHit,
  output mem_guard_pkg::perm_t          selPerm,
  output logic                          anyEn
);
  import mem_guard_pkg::*;

  logic [ADDR_W-1:0] addrQ [NUM_REGIONS];
  entry_cfg_t        cfgQ  [NUM_REGIONS];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_entry
    logic [ADDR_W-1:0] lowBound;
    logic              hitSel;

    assign hitSel = (strobe.idx == MAX_IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrQ[g] <= '0;
        cfgQ[g]  <= '0;
      end else begin
        if (strobe.addrWr && hitSel) addrQ[g] <= wdata;
        if (strobe.cfgWr && hitSel)  cfgQ[g]  <= entry_cfg_t'(wdata[7:0]);
      end
    end

    if (g == 0) begin : g_base
      assign lowBound = '0;
    end else begin : g_chain
      assign lowBound = addrQ[g-1];
    end

    mem_guard_match #(.ADDR_W(ADDR_W)) i_match (
      .lowBound  (lowBound),
      .highBound (addrQ[g]),
      .addr      (chkAddr),
      .mode      (cfgQ[g].mode),
      .hit       (matchVec[g])
    );

    assign lockVec[g] = cfgQ[g].lock;
    assign enVec[g]   = (cfgQ[g].mode == MODE_RANGE);
  end

  assign anyEn = |enVec;

  always_comb begin
    selVec  = '0;
    selHit  = 1'b0;
    selPerm = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (!selHit && matchVec[i]) begin
        selHit       = 1'b1;
        selVec[i]    = 1'b1;
        selPerm.r    = cfgQ[i].r;
        selPerm.w    = cfgQ[i].w;
        selPerm.x    = cfgQ[i].x;
        selPerm.lock = cfgQ[i].lock;
      end
    end
  end

endmodule

// File: rtl/mem_guard_ctrl.sv
module mem_guard_ctrl #(
  parameter int NUM_REGIONS = 16,
  parameter int IDX_W       = 4
) (
  input  logic                      cfgWe,
  input  logic [1:0]                cfgPriv,
  input  logic                      cfgSel,
  input  logic [IDX_W-1:0]          cfgIdx,
  input  logic [NUM_REGIONS-1:0]    lockVec,
  input  logic [1:0]                chkType,
  input  logic [1:0]                chkPriv,
  input  logic                      selHit,
  input  mem_guard_pkg::perm_t      selPerm,
  input  logic                      anyEn,
  output mem_guard_pkg::wr_strobe_t strobe,
  output logic                      chkAllow
);
  import mem_guard_pkg::*;

  logic idxOk;
  logic idxLocked;
  logic wrOk;
  logic permBit;
  logic isMach;

  always_comb begin
    idxOk     = 1'b0;
    idxLocked = 1'b0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (cfgIdx == IDX_W'(i)) begin
        idxOk     = 1'b1;
        idxLocked = lockVec[i];
      end
    end
  end

  assign wrOk          = cfgWe && (cfgPriv == PRIV_MACH) && idxOk && !idxLocked;
  assign strobe.addrWr = wrOk && !cfgSel;
  assign strobe.cfgWr  = wrOk && cfgSel;
  assign strobe.idx    = MAX_IDX_W'(cfgIdx);

  always_comb begin
    case (chkType)
      ACC_READ:  permBit = selPerm.r;
      ACC_WRITE: permBit = selPerm.w;
      ACC_EXEC:  permBit = selPerm.x;
      default:   permBit = 1'b0;
    endcase
  end

  assign isMach = (chkPriv == PRIV_MACH);

  always_comb begin
    if (selHit) begin
      if (isMach && !selPerm.lock) chkAllow = 1'b1;
      else                         chkAllow = permBit;
    end else begin
      chkAllow = isMach || !anyEn;
    end
  end

endmodule

// File: rtl/mem_guard.sv
module mem_guard #(
  parameter int NUM_REGIONS = 16,
  parameter int ADDR_W      = 32,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgPriv,
  input  logic              cfgSel,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ADDR_W-1:0] cfgWdata,
  input  logic [ADDR_W-1:0] chkAddr,
  input  logic [1:0]        chkType,
  input  logic [1:0]        chkPriv,
  output logic              chkAllow
);
  import mem_guard_pkg::*;

  wr_strobe_t             strobe;
  perm_t                  selPerm;
  logic                   selHit;
  logic                   anyEn;
  logic [NUM_REGIONS-1:0] lockVec;
  logic [NUM_REGIONS-1:0] enVec;
  logic [NUM_REGIONS-1:0] matchVec;
  logic [NUM_REGIONS-1:0] selVec;

  mem_guard_ctrl #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) i_ctrl (
    .cfgWe    (cfgWe),
    .cfgPriv  (cfgPriv),
    .cfgSel   (cfgSel),
    .cfgIdx   (cfgIdx),
    .lockVec  (lockVec),
    .chkType  (chkType),
    .chkPriv  (chkPriv),
    .selHit   (selHit),
    .selPerm  (selPerm),
    .anyEn    (anyEn),
    .strobe   (strobe),
    .chkAllow (chkAllow)
  );

  mem_guard_dp #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wdata    (cfgWdata),
    .chkAddr  (chkAddr),
    .lockVec  (lockVec),
    .enVec    (enVec),
    .matchVec (matchVec),
    .selVec   (selVec),
    .selHit   (selHit),
    .selPerm  (selPerm),
    .anyEn    (anyEn)
  );

endmodule

// File: rtl/mem_guard_sva.sv
module mem_guard_sva #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         cfgWe,
  input logic [1:0]   cfgPriv,
  input logic [1:0]   chkPriv,
  input logic [1:0]   chkType,
  input logic         chkAllow,
  input logic [N-1:0] lockVec,
  input logic [N-1:0] enVec,
  input logic [N-1:0] matchVec,
  input logic [N-1:0] selVec
);

  // R2
  priv_write_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgPriv != 2'b11) |=> ($stable(lockVec) && $stable(enVec)));

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|lockVec) |=> ((lockVec & $past(lockVec)) == $past(lockVec)));

  // R6
  single_decider_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selVec));

  // R6
  lowest_decider_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|matchVec) |-> ((selVec != '0) && ((selVec & ~matchVec) == '0)
                     && (((selVec - 1'b1) & matchVec) == '0)));

  // R7
  open_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enVec == '0) |-> chkAllow);

  // R8
  mach_unlocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chkPriv == 2'b11 && lockVec == '0) |-> chkAllow);

  // R5
  rsvd_type_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|matchVec) && chkType == 2'b11 && chkPriv != 2'b11) |-> !chkAllow);

  // R10
  off_never_hits_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((matchVec & ~enVec) == '0));

endmodule

bind mem_guard mem_guard_sva #(.N(NUM_REGIONS)) i_sva (
  .clk      (clk),
  .rstN     (rstN),
  .cfgWe    (cfgWe),
  .cfgPriv  (cfgPriv),
  .chkPriv  (chkPriv),
  .chkType  (chkType),
  .chkAllow (chkAllow),
  .lockVec  (lockVec),
  .enVec    (enVec),
  .matchVec (matchVec),
  .selVec   (selVec)
);

// File: tb/test_mem_guard.sv
`timescale 1ns/1ps
module test_mem_guard;

  localparam int NR    = 6;
  localparam int AW    = 16;
  localparam int IW    = 3;

  localparam logic [1:0] U = 2'b00, S = 2'b01, M = 2'b11;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2, RSV = 2'd3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [1:0]    cfgPriv = 2'b00;
  logic          cfgSel = 1'b0;
  logic [IW-1:0] cfgIdx = '0;
  logic [AW-1:0] cfgWdata = '0;
  logic [AW-1:0] chkAddr = '0;
  logic [1:0]    chkType = 2'd0;
  logic [1:0]    chkPriv = 2'b00;
  logic          chkAllow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mem_guard #(.NUM_REGIONS(NR), .ADDR_W(AW)) i_mem_guard (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgPriv(cfgPriv), .cfgSel(cfgSel),
    .cfgIdx(cfgIdx), .cfgWdata(cfgWdata), .chkAddr(chkAddr), .chkType(chkType),
    .chkPriv(chkPriv), .chkAllow(chkAllow)
  );

  task automatic wr(input logic sel, input int idx, input logic [AW-1:0] data,
                    input logic [1:0] priv);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgIdx = IW'(idx); cfgWdata = data; cfgPriv = priv;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic chk(input logic [AW-1:0] a, input logic [1:0] t,
                     input logic [1:0] p, input logic exp, input string req);
    @(negedge clk);
    chkAddr = a; chkType = t; chkPriv = p;
    #1;
    checks++;
    if (chkAllow !== exp) begin
      failures++;
      $display("FAIL %s addr=%h type=%0d priv=%0d actual=%b expected=%b",
               req, a, t, p, chkAllow, exp);
    end
  endtask

  task automatic t_reset;
    chk(16'h1234, RD, U, 1'b1, "R1");
    chk(16'hFFFF, WR, S, 1'b1, "R1");
    chk(16'h0000, EX, M, 1'b1, "R1");
  endtask

  task automatic t_basic;
    wr(1'b0, 0, 16'h1000, M); wr(1'b1, 0, 16'h0009, M); // R only
    wr(1'b0, 1, 16'h2000, M); wr(1'b1, 1, 16'h000B, M); // R W
    wr(1'b0, 2, 16'h3000, M); wr(1'b1, 2, 16'h000C, M); // X only
    chk(16'h0800, RD, U, 1'b1, "R3 R4");
    chk(16'h0800, WR, U, 1'b0, "R5");
    chk(16'h0FFF, WR, S, 1'b0, "R4");
    chk(16'h1000, WR, U, 1'b1, "R4");
    chk(16'h2FFF, EX, U, 1'b1, "R5");
    chk(16'h2FFF, RD, U, 1'b0, "R5");
    chk(16'h1800, RSV, U, 1'b0, "R5");
    chk(16'h3000, RD, U, 1'b0, "R7");
    chk(16'h0800, WR, M, 1'b1, "R8");
    chk(16'hF000, EX, M, 1'b1, "R8");
  endtask

  task automatic t_modes_and_priority;
    wr(1'b0, 3, 16'h0000, M); wr(1'b1, 3, 16'h000F, M);
    chk(16'h3800, RD, U, 1'b0, "R10 empty range");
    wr(1'b0, 3, 16'h9000, M); wr(1'b1, 3, 16'h0017, M);
    chk(16'h3800, RD, U, 1'b0, "R10 reserved mode");
    wr(1'b1, 3, 16'h000F, M);
    chk(16'h3800, RD, U, 1'b1, "R4");
    chk(16'h8FFF, WR, U, 1'b1, "R3");
    wr(1'b0, 4, 16'h0000, M);
    wr(1'b0, 5, 16'h8000, M); wr(1'b1, 5, 16'h000F, M);
    chk(16'h0800, WR, U, 1'b0, "R6");
    chk(16'h0800, EX, U, 1'b0, "R6");
    chk(16'h5000, WR, U, 1'b1, "R6");
    chk(16'hA000, RD, U, 1'b0, "R7");
  endtask

  task automatic t_write_guard;
    wr(1'b1, 0, 16'h000F, U);
    chk(16'h0800, WR, U, 1'b0, "R2 user write");
    wr(1'b1, 0, 16'h000F, S);
    chk(16'h0800, WR, U, 1'b0, "R2 super write");
    wr(1'b0, 6, 16'hFFFF, M); wr(1'b1, 6, 16'h000F, M);
    wr(1'b0, 7, 16'hFFFF, M); wr(1'b1, 7, 16'h000F, M);
    chk(16'hA000, RD, U, 1'b0, "R2 index range");
  endtask

  task automatic t_lock;
    wr(1'b1, 0, 16'h0089, M);
    chk(16'h0800, WR, M, 1'b0, "R8 locked");
    chk(16'h0800, RD, M, 1'b1, "R8 locked");
    wr(1'b1, 0, 16'h000F, M);
    chk(16'h0800, WR, U, 1'b0, "R9 setting");
    wr(1'b0, 0, 16'h0100, M);
    chk(16'h0900, RD, U, 1'b1, "R9 bound");
    chk(16'h1800, WR, M, 1'b1, "R8 unlocked");
    chk(16'hA000, EX, M, 1'b1, "R8 no match");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_basic();
    t_modes_and_priority();
    t_write_guard();
    t_lock();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1..all actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule